// File: doc/BRIEF.md
# Triggered Clock Glitch Inserter

This block derives a target clock from a fast reference clock by even division with a 50 % duty cycle. It can also splice one premature clock pulse into that clock. Before each attempt, a host sets the cycle offset and the pulse width and strobes the arm input. When an external trigger then rises, for example the target's reset release or a marker pin toggled by firmware, the block counts whole target-clock cycles. It then drives one short extra high pulse inside the low half of the chosen cycle. That pulse gives the target a rising edge too early for its slow paths to settle, and every other cycle of the clock is left unchanged.

An output select decides whether the pin carries the clock with the spliced pulse or the undisturbed divided clock. A busy flag spans the attempt and a one-cycle done pulse marks its end. Each arm allows exactly one attempt, so a host sweeping the offset across a window re-arms and rewrites the offset between attempts. The offset and width are captured when the trigger is detected, so later writes only affect the next attempt.

Top module: `clk_glitch_gen`

## Requirements
- R1: After reset, tgt_clk, busy and done are low. Counting n as the reference edges since reset release, tgt_clk is high in cycle n exactly when (n-1) mod (2*HALF_DIV) < HALF_DIV, unless a pulse is being inserted.
- R2: The trigger passes through a two-flop synchronizer and only its rising edge counts. For a trigger that rises after reference edge t, busy is first high after edge t+3.
- R3: Take b as the first edge after detection at which a new target cycle begins. The glitch cycle starts offset whole target cycles after b, so offset 0 selects the first cycle after detection. In that cycle tgt_clk is also high for W reference cycles that end one reference cycle before the next normal rising edge.
- R4: The effective width W is the width input clamped to the range 1 to HALF_DIV-2. A high run therefore never exceeds the half-period, and the pulse keeps one low cycle on each side.
- R5: With sel_glitch low, tgt_clk equals the plain divided clock, while busy and done still follow the attempt.
- R6: busy is high from detection through the last pulse cycle but one. done is high for exactly one cycle, aligned with the last high cycle of the inserted pulse, and busy is low in that cycle.
- R7: A trigger while not armed is ignored, and after done the block stays idle until a new arm strobe.
- R8: offset and width are sampled at trigger detection. Changing them while busy does not move or resize the pulse, and an arm strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous external trigger, rising edge used |
| arm | input | 1 | One-cycle strobe enabling a single attempt |
| offset | input | OFS_W | Target-cycle offset from trigger to glitch cycle |
| width | input | WID_W | Requested pulse width in reference cycles |
| sel_glitch | input | 1 | 1 selects the glitched clock, 0 the plain clock |
| tgt_clk | output | 1 | Registered target clock |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle end-of-attempt pulse |

## Verification
Busy rises three reference edges after the trigger, because of the two-flop synchronizer and the edge-detect register. The glitch cycle starts at the first target-cycle boundary after detection plus offset times the target period. The pulse appears on tgt_clk one register later, in the last W cycles of that period, and done coincides with the last pulse cycle. The bench computes these edge numbers from the reference edges it counts after reset and pushes them into a queue. A monitor compares all three outputs on every falling clock edge, so each output is sampled half a reference period after the edge that set it.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_GLITCH = 2'd3
    } shot_state_e;

    typedef struct packed {
        logic base_hi;    // plain divided clock level for the current phase
        logic cycle_end;  // last reference cycle of a target period
    } div_status_t;

    // Limit the requested pulse width so one low cycle stays on each side.
    function automatic int clamp_width(input int req, input int half);
        int lim;
        lim = half - 2;
        if (req < 1)
            return 1;
        else if (req > lim)
            return lim;
        return req;
    endfunction

endpackage

// File: rtl/cg_clk_div.sv
module cg_clk_div
    import cg_pkg::*;
#(
    parameter int HALF_DIV = 6,
    parameter int PH_W     = $clog2(2 * HALF_DIV)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output div_status_t     st
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_DIV);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (ph_q == PH_LAST)
            ph_q <= '0;
        else
            ph_q <= ph_q + PH_W'(1);
    end

    always_comb begin
        st.base_hi   = (ph_q < PH_HALF);
        st.cycle_end = (ph_q == PH_LAST);
    end

    assign ph = ph_q;

endmodule

// File: rtl/cg_trig_sync.sv
module cg_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic rise
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], trig_in};
    end

    assign rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

endmodule

// File: rtl/cg_shot_fsm.sv
module cg_shot_fsm
    import cg_pkg::*;
#(
    parameter int HALF_DIV = 6,
    parameter int PH_W     = $clog2(2 * HALF_DIV),
    parameter int OFS_W    = 16,
    parameter int WID_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             rise,
    input  logic [PH_W-1:0]  ph,
    input  logic             cycle_end,
    input  logic [OFS_W-1:0] offset,
    input  logic [WID_W-1:0] width,
    output logic             pulse_on,
    output logic             busy,
    output logic             done
);
    localparam logic [PH_W-1:0] PH_PEN  = PH_W'(2 * HALF_DIV - 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_DIV - 1);

    shot_state_e      state_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] cyc_q;
    logic [PH_W-1:0]  wid_q;
    logic [PH_W-1:0]  win_lo;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ofs_q   <= '0;
            cyc_q   <= '0;
            wid_q   <= PH_W'(1);
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (arm)
                        state_q <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (rise) begin
                        state_q <= ST_WAIT;
                        ofs_q   <= offset;
                        wid_q   <= PH_W'(clamp_width(int'(width), HALF_DIV));
                        cyc_q   <= '0;
                    end
                end
                ST_WAIT: begin
                    if (cycle_end) begin
                        if (cyc_q == ofs_q)
                            state_q <= ST_GLITCH;
                        else
                            cyc_q <= cyc_q + OFS_W'(1);
                    end
                end
                ST_GLITCH: begin
                    if (ph == PH_PEN) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign win_lo   = PH_LAST - wid_q;
    assign pulse_on = (state_q == ST_GLITCH) && (ph >= win_lo) && (ph <= PH_PEN);
    assign busy     = (state_q == ST_WAIT) || (state_q == ST_GLITCH);
    assign done     = done_q;

endmodule

// File: rtl/clk_glitch_gen.sv
module clk_glitch_gen
    import cg_pkg::*;
#(
    parameter int HALF_DIV = 6,
    parameter int OFS_W    = 16,
    parameter int WID_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             arm,
    input  logic [OFS_W-1:0] offset,
    input  logic [WID_W-1:0] width,
    input  logic             sel_glitch,
    output logic             tgt_clk,
    output logic             busy,
    output logic             done
);
    localparam int PH_W = $clog2(2 * HALF_DIV);

    logic [PH_W-1:0] ph;
    div_status_t     dst;
    logic            trig_rise;
    logic            pulse_on;
    logic            tgt_q;

    cg_clk_div #(
        .HALF_DIV (HALF_DIV),
        .PH_W     (PH_W)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .st  (dst)
    );

    cg_trig_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .rise    (trig_rise)
    );

    cg_shot_fsm #(
        .HALF_DIV (HALF_DIV),
        .PH_W     (PH_W),
        .OFS_W    (OFS_W),
        .WID_W    (WID_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .rise      (trig_rise),
        .ph        (ph),
        .cycle_end (dst.cycle_end),
        .offset    (offset),
        .width     (width),
        .pulse_on  (pulse_on),
        .busy      (busy),
        .done      (done)
    );

    // Registered output stage keeps the pin free of combinational hazards.
    always_ff @(posedge clk) begin
        if (rst)
            tgt_q <= 1'b0;
        else if (sel_glitch)
            tgt_q <= dst.base_hi | pulse_on;
        else
            tgt_q <= dst.base_hi;
    end

    assign tgt_clk = tgt_q;

endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
    parameter int HALF_DIV = 6,
    parameter int PH_W     = $clog2(2 * HALF_DIV)
) (
    input logic            clk,
    input logic            rst,
    input logic            tgt_clk,
    input logic            busy,
    input logic            done,
    input logic            trig_rise,
    input logic            pulse_on,
    input logic [PH_W-1:0] ph
);
    localparam logic [PH_W-1:0] LOW_FIRST = PH_W'(HALF_DIV + 1);
    localparam logic [PH_W-1:0] LOW_PEN   = PH_W'(2 * HALF_DIV - 2);

    int hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 0;
        else if (tgt_clk)
            hi_run <= (hi_run < HALF_DIV + 2) ? hi_run + 1 : hi_run;
        else
            hi_run <= 0;
    end

    AST_BUSY_FROM_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig_rise)); // R2

    AST_PULSE_IN_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        pulse_on |-> (ph >= LOW_FIRST && ph <= LOW_PEN)); // R3

    AST_HIGH_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        hi_run <= HALF_DIV); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R6

    AST_BUSY_FELL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R6

endmodule

bind clk_glitch_gen cg_checker #(
    .HALF_DIV (HALF_DIV),
    .PH_W     (PH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tgt_clk   (tgt_clk),
    .busy      (busy),
    .done      (done),
    .trig_rise (trig_rise),
    .pulse_on  (pulse_on),
    .ph        (ph)
);

// File: tb/clk_glitch_gen_tb.sv
`timescale 1ns/1ps
module clk_glitch_gen_tb;
    localparam int HALF  = 6;
    localparam int P     = 2 * HALF;
    localparam int OFS_W = 16;
    localparam int WID_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_in = 1'b0;
    logic             arm = 1'b0;
    logic [OFS_W-1:0] offset = '0;
    logic [WID_W-1:0] width = '0;
    logic             sel_glitch = 1'b0;
    logic             tgt_clk, busy, done;

    always #2.5 clk = ~clk;

    clk_glitch_gen #(
        .HALF_DIV (HALF),
        .OFS_W    (OFS_W),
        .WID_W    (WID_W)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .arm        (arm),
        .offset     (offset),
        .width      (width),
        .sel_glitch (sel_glitch),
        .tgt_clk    (tgt_clk),
        .busy       (busy),
        .done       (done)
    );

    typedef struct {
        int          d;
        int          g;
        int          w;
        bit          sel;
        logic [15:0] tag;
    } shot_t;

    shot_t q[$];
    int    n = 0;
    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic chk(input bit ok, input logic [15:0] tag, input int act,
                       input int exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at n=%0d: actual=%0d expected=%0d", tag, what, n, act, exp);
        end
    endtask

    // Monitor: pops expected attempts and compares every output each cycle.
    always @(negedge clk) begin
        if (!finished) begin
            if (rst) begin
                chk(tgt_clk == 1'b0, "R1", int'(tgt_clk), 0, "tgt_clk in reset");
                chk(busy == 1'b0, "R1", int'(busy), 0, "busy in reset");
                chk(done == 1'b0, "R1", int'(done), 0, "done in reset");
            end else begin
                bit          e_clk, e_busy, e_done, do_pop;
                logic [15:0] ctag, btag;
                e_clk  = (n >= 1) && (((n - 1) % P) < HALF);
                e_busy = 1'b0;
                e_done = 1'b0;
                do_pop = 1'b0;
                ctag   = "R1";
                btag   = "R7";
                if (q.size() > 0) begin
                    shot_t h;
                    int lo, hi;
                    h  = q[0];
                    lo = h.g + P - h.w;
                    hi = h.g + P - 1;
                    btag = (n == h.d) ? "R2" : "R6";
                    if (n >= h.d && n <= h.g + P - 2) e_busy = 1'b1;
                    if (n == hi) e_done = 1'b1;
                    if (n >= lo && n <= hi) begin
                        if (h.sel) begin
                            e_clk = 1'b1;
                            ctag  = h.tag;
                        end else begin
                            ctag  = "R5";
                        end
                    end
                    if (n >= hi) do_pop = 1'b1;
                end
                chk(tgt_clk == e_clk, ctag, int'(tgt_clk), int'(e_clk), "tgt_clk");
                chk(busy == e_busy, btag, int'(busy), int'(e_busy), "busy");
                chk(done == e_done, "R6", int'(done), int'(e_done), "done");
                if (do_pop) void'(q.pop_front());
            end
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        tick(1);
        arm = 1'b0;
    endtask

    // Driver: fires one trigger and pushes the expected timing of the attempt.
    task automatic shot(input int ofs, input int w, input bit sel,
                        input logic [15:0] tag, input bit change_mid, input bit arm_mid);
        shot_t it;
        int    t, b0, weff;
        offset     = OFS_W'(ofs);
        width      = WID_W'(w);
        sel_glitch = sel;
        tick(1);
        t  = n;
        trig_in = 1'b1;
        it.d = t + 3;
        b0 = it.d + 1;
        while ((b0 % P) != 0) b0++;
        it.g = b0 + P * ofs;
        weff = (w < 1) ? 1 : ((w > HALF - 2) ? HALF - 2 : w);
        it.w   = weff;
        it.sel = sel;
        it.tag = tag;
        q.push_back(it);
        tick(4);
        trig_in = 1'b0;
        if (change_mid) begin
            offset = OFS_W'(ofs + 5);
            width  = WID_W'(1);
        end
        if (arm_mid) do_arm();
        while (n <= it.g + P + 1) tick(1);
        tick(2);
    endtask

    task automatic stray_trigger();
        trig_in = 1'b1;
        tick(4);
        trig_in = 1'b0;
        tick(3 * P);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2 * P);                                // R1 plain clock
        stray_trigger();                            // R7 not armed
        do_arm();
        shot(0, 2, 1'b1, "R3", 1'b0, 1'b0);         // R3 offset zero
        stray_trigger();                            // R7 single shot
        do_arm();
        shot(3, 0, 1'b1, "R4", 1'b0, 1'b0);         // R4 clamp up to 1
        do_arm();
        shot(2, 15, 1'b1, "R4", 1'b0, 1'b0);        // R4 clamp down to HALF-2
        do_arm();
        shot(2, 3, 1'b1, "R8", 1'b1, 1'b0);         // R8 inputs change mid-attempt
        do_arm();
        shot(1, 3, 1'b0, "R5", 1'b0, 1'b0);         // R5 plain output selected
        do_arm();
        shot(1, 2, 1'b1, "R8", 1'b0, 1'b1);         // R8 arm while busy ignored
        stray_trigger();                            // R8 no re-arm took effect
        for (int o = 4; o <= 8; o += 2) begin       // R3 offset sweep
            do_arm();
            shot(o, 4, 1'b1, "R3", 1'b0, 1'b0);
        end
        tick(P);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        finished = 1'b1;
        total++;
        bad++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule